// File: doc/BRIEF.md
# Software Interrupt Source Tracker

This block keeps the pending state of the sixteen inter-processor software interrupts of a four-core interrupt distributor. Each interrupt number has its own pending bit for every pair of target core and requesting core. A software interrupt request names an interrupt number, a mask of target cores and the requesting core. It sets one bit for each target in the mask. Because the requesting core is recorded, two cores that raise the same number towards the same target are kept apart rather than merged.

A target core acknowledges through a strobe that names the core. One cycle later the block returns a 13-bit acknowledge word. Bits 9:0 hold the interrupt ID and bits 12:10 hold the requesting core. When several numbers are pending, the lowest number is returned. When several cores requested that number, the lowest-numbered requesting core is returned. Only that one source bit is cleared, so the interrupt stays pending while other requesters remain. A core with nothing pending receives the spurious ID 1023.

The parameter `HAS_SGI` selects the variant. When it is 0, the block has no software interrupts. Its sixteen entries then act as ordinary pending flags that the generic set/clear write port drives. Acknowledge in this variant returns the ID with a zero source field and does not look at any requester. With `HAS_SGI` at 1, the generic write port cannot touch software interrupt state.

Top module: `sgi_track`

## Requirements
- R1: While reset is low and in the first cycle after it, `corePending` is all zero and `respValid` is low.
- R2: With HAS_SGI=1, a request (`sgiValid`) marks interrupt `sgiId` pending from core `sgiSource` for every core whose bit is set in `sgiTargets` (bit c = core c). The matching `corePending` bits are high after the next clock edge, and other cores are unchanged.
- R3: An acknowledge strobe (`ackValid`, `ackCore`) produces `respValid` high for exactly one cycle, after the next clock edge. `respData` then holds the lowest pending interrupt number of that core in bits 9:0 and the source core in bits 12:10, so the value is source*1024 + id.
- R4: When several cores requested the same number for one target, acknowledge reports the lowest-numbered requesting core first.
- R5: An acknowledge clears only the reported (number, target, source) bit. The target stays pending while any other source bit remains, and later acknowledges return the remaining sources in ascending order.
- R6: An acknowledge from a core with nothing pending returns 1023 with a zero source field, and changes no state.
- R7: If a request sets the same bit that an acknowledge clears in the same cycle, the bit remains set.
- R8: With HAS_SGI=1, generic writes (`genValid`) leave all software interrupt state unchanged, whether they set or clear.
- R9: With HAS_SGI=0, requests are ignored. A generic set (`genSet`=1) or clear (`genSet`=0) of an ID below 16 for core `genCore` sets or clears a plain pending flag, and IDs of 16 or more are ignored. Acknowledge returns the lowest flagged ID with source field 0 and clears that flag.
- R10: An acknowledge by one core never changes the pending state of another core.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sgiValid | input | 1 | Software interrupt request strobe |
| sgiId | input | 4 | Requested interrupt number |
| sgiTargets | input | 4 | Target core mask, bit c = core c |
| sgiSource | input | 2 | Requesting core |
| genValid | input | 1 | Generic pending write strobe |
| genSet | input | 1 | 1 = set pending, 0 = clear pending |
| genId | input | 10 | Interrupt ID of the generic write |
| genCore | input | 2 | Core whose flag the generic write addresses |
| ackValid | input | 1 | Acknowledge strobe |
| ackCore | input | 2 | Acknowledging core |
| respValid | output | 1 | Acknowledge word valid, one cycle after the strobe |
| respData | output | 13 | {source[2:0], id[9:0]}, or 1023 for spurious |
| corePending | output | 4 | Per core, any interrupt pending |

## Verification
A wrong bit in the source matrix shows up at the ports in one of two ways: as a `corePending` bit that differs right after the edge that should have changed it, or as a wrong source field in the acknowledge word one cycle after the strobe. A bit that was never cleared makes a later acknowledge repeat the same source instead of moving to the next one or returning 1023. A bit that was lost makes the acknowledge skip a source. Draining every target to the spurious value after each scenario therefore exposes leftover state within a few cycles. The sweep pairs every interrupt number with every requesting core to catch swapped or truncated fields.

// File: rtl/sgi_track_pkg.sv
package sgi_track_pkg;
  localparam int SGI_CORES = 4;
  localparam int SGI_COUNT = 16;
  localparam int CORE_W    = $clog2(SGI_CORES);
  localparam int NUM_W     = $clog2(SGI_COUNT);
  localparam int INTID_W   = 10;
  localparam int SRCF_W    = 3;
  localparam int RESP_W    = SRCF_W + INTID_W;
  localparam logic [INTID_W-1:0] SPURIOUS_ID = INTID_W'(1023);

  // Strobes from control to the pending store
  typedef struct packed {
    logic                 setEn;
    logic [NUM_W-1:0]     setNum;
    logic [SGI_CORES-1:0] setTargets;
    logic [CORE_W-1:0]    setSlot;
    logic                 ackClrEn;
    logic [NUM_W-1:0]     ackClrNum;
    logic [CORE_W-1:0]    ackClrCore;
    logic [CORE_W-1:0]    ackClrSlot;
    logic                 genClrEn;
    logic [NUM_W-1:0]     genClrNum;
    logic [CORE_W-1:0]    genClrCore;
  } strobes_t;
endpackage

// File: rtl/sgi_track_store.sv
module sgi_track_store
  import sgi_track_pkg::*;
#(
  parameter int HAS_SGI = 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobes_t             strb,
  input  logic [CORE_W-1:0]    selCore,
  output logic                 selFound,
  output logic [NUM_W-1:0]     selNum,
  output logic [CORE_W-1:0]    selSlot,
  output logic [SGI_CORES-1:0] corePending
);
  // One slot per requesting core when tracking sources, else one plain flag
  localparam int SLOTS = (HAS_SGI != 0) ? SGI_CORES : 1;

  logic [SGI_COUNT-1:0][SGI_CORES-1:0][SLOTS-1:0] pend;
  logic [SGI_COUNT-1:0][SGI_CORES-1:0][SLOTS-1:0] pendNext;

  always_comb begin
    pendNext = pend;
    for (int n = 0; n < SGI_COUNT; n++) begin
      for (int c = 0; c < SGI_CORES; c++) begin
        for (int s = 0; s < SLOTS; s++) begin
          if (strb.ackClrEn && n == int'(strb.ackClrNum) &&
              c == int'(strb.ackClrCore) && s == int'(strb.ackClrSlot))
            pendNext[n][c][s] = 1'b0;
          if (strb.genClrEn && n == int'(strb.genClrNum) &&
              c == int'(strb.genClrCore) && s == 0)
            pendNext[n][c][s] = 1'b0;
          // set applied last: a same-cycle request survives the clear
          if (strb.setEn && n == int'(strb.setNum) &&
              strb.setTargets[c] && s == int'(strb.setSlot))
            pendNext[n][c][s] = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pend <= '0;
    else       pend <= pendNext;
  end

  // Lowest number first, then lowest requesting core
  always_comb begin
    selFound = 1'b0;
    selNum   = '0;
    selSlot  = '0;
    for (int n = SGI_COUNT - 1; n >= 0; n--) begin
      if (|pend[n][selCore]) begin
        selFound = 1'b1;
        selNum   = NUM_W'(n);
      end
    end
    for (int s = SLOTS - 1; s >= 0; s--) begin
      if (pend[selNum][selCore][s]) selSlot = CORE_W'(s);
    end
  end

  always_comb begin
    corePending = '0;
    for (int c = 0; c < SGI_CORES; c++) begin
      for (int n = 0; n < SGI_COUNT; n++) begin
        corePending[c] = corePending[c] | (|pend[n][c]);
      end
    end
  end
endmodule

// File: rtl/sgi_track_ctrl.sv
module sgi_track_ctrl
  import sgi_track_pkg::*;
#(
  parameter int HAS_SGI = 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 sgiValid,
  input  logic [NUM_W-1:0]     sgiId,
  input  logic [SGI_CORES-1:0] sgiTargets,
  input  logic [CORE_W-1:0]    sgiSource,
  input  logic                 genValid,
  input  logic                 genSet,
  input  logic [INTID_W-1:0]   genId,
  input  logic [CORE_W-1:0]    genCore,
  input  logic                 ackValid,
  input  logic [CORE_W-1:0]    ackCore,
  input  logic                 selFound,
  input  logic [NUM_W-1:0]     selNum,
  input  logic [CORE_W-1:0]    selSlot,
  output strobes_t             strb,
  output logic                 respValid,
  output logic [RESP_W-1:0]    respData
);
  localparam logic TRACK_SRC = (HAS_SGI != 0);

  logic genInRange;
  logic [SGI_CORES-1:0] genTarget;
  logic [SRCF_W-1:0] srcField;

  assign genInRange = genId < INTID_W'(SGI_COUNT);
  assign genTarget  = SGI_CORES'(1) << genCore;
  assign srcField   = TRACK_SRC ? SRCF_W'(selSlot) : '0;

  always_comb begin
    strb = '0;
    // Source-tracking variant takes requests; plain variant takes generic writes
    strb.setEn      = TRACK_SRC ? sgiValid
                                : (genValid && genSet && genInRange);
    strb.setNum     = TRACK_SRC ? sgiId : genId[NUM_W-1:0];
    strb.setTargets = TRACK_SRC ? sgiTargets : genTarget;
    strb.setSlot    = TRACK_SRC ? sgiSource : '0;
    strb.genClrEn   = !TRACK_SRC && genValid && !genSet && genInRange;
    strb.genClrNum  = genId[NUM_W-1:0];
    strb.genClrCore = genCore;
    strb.ackClrEn   = ackValid && selFound;
    strb.ackClrNum  = selNum;
    strb.ackClrCore = ackCore;
    strb.ackClrSlot = selSlot;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      respValid <= 1'b0;
      respData  <= '0;
    end else begin
      respValid <= ackValid;
      if (ackValid) begin
        respData <= selFound ? {srcField, INTID_W'(selNum)}
                             : {SRCF_W'(0), SPURIOUS_ID};
      end
    end
  end
endmodule

// File: rtl/sgi_track.sv
module sgi_track
  import sgi_track_pkg::*;
#(
  parameter int HAS_SGI = 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 sgiValid,
  input  logic [NUM_W-1:0]     sgiId,
  input  logic [SGI_CORES-1:0] sgiTargets,
  input  logic [CORE_W-1:0]    sgiSource,
  input  logic                 genValid,
  input  logic                 genSet,
  input  logic [INTID_W-1:0]   genId,
  input  logic [CORE_W-1:0]    genCore,
  input  logic                 ackValid,
  input  logic [CORE_W-1:0]    ackCore,
  output logic                 respValid,
  output logic [RESP_W-1:0]    respData,
  output logic [SGI_CORES-1:0] corePending
);
  strobes_t          strb;
  logic              selFound;
  logic [NUM_W-1:0]  selNum;
  logic [CORE_W-1:0] selSlot;

  sgi_track_ctrl #(.HAS_SGI(HAS_SGI)) uCtrl (
    .clk(clk), .rstN(rstN),
    .sgiValid(sgiValid), .sgiId(sgiId), .sgiTargets(sgiTargets),
    .sgiSource(sgiSource), .genValid(genValid), .genSet(genSet),
    .genId(genId), .genCore(genCore), .ackValid(ackValid),
    .ackCore(ackCore), .selFound(selFound), .selNum(selNum),
    .selSlot(selSlot), .strb(strb), .respValid(respValid),
    .respData(respData)
  );

  sgi_track_store #(.HAS_SGI(HAS_SGI)) uStore (
    .clk(clk), .rstN(rstN), .strb(strb), .selCore(ackCore),
    .selFound(selFound), .selNum(selNum), .selSlot(selSlot),
    .corePending(corePending)
  );
endmodule

// File: rtl/sgi_track_chk.sv
module sgi_track_chk
  import sgi_track_pkg::*;
#(
  parameter int HAS_SGI = 1
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 sgiValid,
  input logic [NUM_W-1:0]     sgiId,
  input logic [SGI_CORES-1:0] sgiTargets,
  input logic [CORE_W-1:0]    sgiSource,
  input logic                 genValid,
  input logic                 genSet,
  input logic [INTID_W-1:0]   genId,
  input logic [CORE_W-1:0]    genCore,
  input logic                 ackValid,
  input logic [CORE_W-1:0]    ackCore,
  input logic                 respValid,
  input logic [RESP_W-1:0]    respData,
  input logic [SGI_CORES-1:0] corePending
);
  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rstN |=> (!respValid && corePending == '0));

  assert_targets_marked_R2: assert property (@(posedge clk) disable iff (!rstN)
    (HAS_SGI != 0) && $past(sgiValid) |->
      ((corePending & $past(sgiTargets)) == $past(sgiTargets)));

  assert_resp_follows_ack_R3: assert property (@(posedge clk) disable iff (!rstN)
    respValid |-> $past(ackValid));

  assert_resp_id_range_R3: assert property (@(posedge clk) disable iff (!rstN)
    respValid && respData[INTID_W-1:0] != SPURIOUS_ID |->
      respData[INTID_W-1:0] < INTID_W'(SGI_COUNT));

  assert_spurious_no_source_R6: assert property (@(posedge clk) disable iff (!rstN)
    respValid && respData[INTID_W-1:0] == SPURIOUS_ID |->
      respData[RESP_W-1:INTID_W] == '0);

  assert_generic_ignored_R8: assert property (@(posedge clk) disable iff (!rstN)
    (HAS_SGI != 0) && !$past(sgiValid) && !$past(ackValid) |->
      $stable(corePending));

  assert_plain_no_source_R9: assert property (@(posedge clk) disable iff (!rstN)
    (HAS_SGI == 0) && respValid |-> respData[RESP_W-1:INTID_W] == '0);
endmodule

bind sgi_track sgi_track_chk #(.HAS_SGI(HAS_SGI)) uChk (.*);

// File: tb/sim_sgi_track.sv
module sim_sgi_track;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #4 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  // source-tracking instance
  logic sgiValid = 0; logic [3:0] sgiId = 0; logic [3:0] sgiTargets = 0;
  logic [1:0] sgiSource = 0; logic genValid = 0; logic genSet = 0;
  logic [9:0] genId = 0; logic [1:0] genCore = 0;
  logic ackValid = 0; logic [1:0] ackCore = 0;
  logic respValid; logic [12:0] respData; logic [3:0] corePending;

  // plain-flag instance
  logic pSgiValid = 0; logic [3:0] pSgiId = 0; logic [3:0] pSgiTargets = 0;
  logic [1:0] pSgiSource = 0; logic pGenValid = 0; logic pGenSet = 0;
  logic [9:0] pGenId = 0; logic [1:0] pGenCore = 0;
  logic pAckValid = 0; logic [1:0] pAckCore = 0;
  logic pRespValid; logic [12:0] pRespData; logic [3:0] pCorePending;

  sgi_track #(.HAS_SGI(1)) u0 (
    .clk(clk), .rstN(rstN), .sgiValid(sgiValid), .sgiId(sgiId),
    .sgiTargets(sgiTargets), .sgiSource(sgiSource), .genValid(genValid),
    .genSet(genSet), .genId(genId), .genCore(genCore), .ackValid(ackValid),
    .ackCore(ackCore), .respValid(respValid), .respData(respData),
    .corePending(corePending));

  sgi_track #(.HAS_SGI(0)) u1 (
    .clk(clk), .rstN(rstN), .sgiValid(pSgiValid), .sgiId(pSgiId),
    .sgiTargets(pSgiTargets), .sgiSource(pSgiSource), .genValid(pGenValid),
    .genSet(pGenSet), .genId(pGenId), .genCore(pGenCore), .ackValid(pAckValid),
    .ackCore(pAckCore), .respValid(pRespValid), .respData(pRespData),
    .corePending(pCorePending));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic sendSgi(input int id, input int tgt, input int src);
    sgiValid = 1; sgiId = 4'(id); sgiTargets = 4'(tgt); sgiSource = 2'(src);
    @(negedge clk);
    sgiValid = 0;
  endtask

  task automatic doAck(input int core, input int exp, input string req);
    ackValid = 1; ackCore = 2'(core);
    @(negedge clk);
    ackValid = 0;
    chk(req, int'(respValid), 1);
    chk(req, int'(respData), exp);
  endtask

  task automatic genWr(input bit setIt, input int id, input int core);
    genValid = 1; genSet = setIt; genId = 10'(id); genCore = 2'(core);
    @(negedge clk);
    genValid = 0;
  endtask

  task automatic pGenWr(input bit setIt, input int id, input int core);
    pGenValid = 1; pGenSet = setIt; pGenId = 10'(id); pGenCore = 2'(core);
    @(negedge clk);
    pGenValid = 0;
  endtask

  task automatic pAck(input int core, input int exp, input string req);
    pAckValid = 1; pAckCore = 2'(core);
    @(negedge clk);
    pAckValid = 0;
    chk(req, int'(pRespValid), 1);
    chk(req, int'(pRespData), exp);
  endtask

  initial begin
    #(8 * 100000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 pending", int'(corePending), 0);
    chk("R1 resp", int'(respValid), 0);
    rstN = 1;
    @(negedge clk);
    chk("R1 after", int'(corePending), 0);
    chk("R1 after resp", int'(respValid), 0);

    // R6: nothing pending
    doAck(0, 1023, "R6 spurious");
    @(negedge clk);
    chk("R3 single pulse", int'(respValid), 0);

    // R2/R3 sweep: every number with every source
    for (int id = 0; id < 16; id++) begin
      for (int src = 0; src < 4; src++) begin
        int tgt;
        tgt = (id + src) % 4;
        sendSgi(id, 1 << tgt, src);
        chk("R2 set", int'(corePending), 1 << tgt);
        doAck(tgt, src * 1024 + id, "R3 sweep");
        chk("R5 drained", int'(corePending), 0);
      end
    end

    // R4/R5: three sources, same number, same target
    sendSgi(5, 4'b0100, 3);
    sendSgi(5, 4'b0100, 1);
    sendSgi(5, 4'b0100, 2);
    doAck(2, 1 * 1024 + 5, "R4 lowest source");
    chk("R5 still pending", int'(corePending), 4);
    doAck(2, 2 * 1024 + 5, "R5 next source");
    doAck(2, 3 * 1024 + 5, "R5 last source");
    chk("R5 cleared", int'(corePending), 0);
    doAck(2, 1023, "R5 empty");

    // R3: lowest number first
    sendSgi(9, 4'b0010, 0);
    sendSgi(3, 4'b0010, 2);
    doAck(1, 2 * 1024 + 3, "R3 lowest id");
    doAck(1, 9, "R3 next id");

    // R10: broadcast, one core acks
    sendSgi(7, 4'b1111, 0);
    chk("R2 broadcast", int'(corePending), 15);
    doAck(3, 7, "R10 ack core3");
    chk("R10 others kept", int'(corePending), 7);
    for (int c = 0; c < 3; c++) doAck(c, 7, "R10 drain");
    chk("R10 empty", int'(corePending), 0);

    // R7: set and clear of the same bit in one cycle
    sendSgi(4, 4'b0001, 1);
    sgiValid = 1; sgiId = 4; sgiTargets = 4'b0001; sgiSource = 1;
    ackValid = 1; ackCore = 0;
    @(negedge clk);
    sgiValid = 0; ackValid = 0;
    chk("R7 resp", int'(respData), 1028);
    chk("R7 kept", int'(corePending), 1);
    doAck(0, 1028, "R7 second");
    doAck(0, 1023, "R7 empty");

    // R8: generic writes do nothing to tracked state
    sendSgi(6, 4'b0001, 2);
    genWr(1'b0, 6, 0);
    chk("R8 clear ignored", int'(corePending), 1);
    genWr(1'b1, 2, 1);
    chk("R8 set ignored", int'(corePending), 1);
    doAck(0, 2 * 1024 + 6, "R8 source kept");
    doAck(1, 1023, "R8 nothing set");

    // R9: plain variant
    pSgiValid = 1; pSgiId = 3; pSgiTargets = 4'b0001; pSgiSource = 1;
    @(negedge clk);
    pSgiValid = 0;
    chk("R9 request ignored", int'(pCorePending), 0);
    pGenWr(1'b1, 11, 2);
    chk("R9 set", int'(pCorePending), 4);
    pAck(2, 11, "R9 ack");
    chk("R9 ack clears", int'(pCorePending), 0);
    pGenWr(1'b1, 12, 1);
    pGenWr(1'b0, 12, 1);
    chk("R9 clear", int'(pCorePending), 0);
    pGenWr(1'b1, 20, 1);
    chk("R9 out of range", int'(pCorePending), 0);
    pAck(1, 1023, "R9 spurious");
    pAck(0, 1023, "R9 request left nothing");

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule